// File: doc/BRIEF.md
# Device Security and Mode Controller

This block decides whether read, program, erase and lock-setting requests from a configuration port may proceed. It holds two lock bits. The read lock stops readback and programming, but it still lets an erase through. The write lock stops both programming and erasing. A request that is let through is granted. A request that is refused raises a one-cycle deny pulse and changes no state. The block also keeps a blank flag that tracks whether the array is erased. The non-volatile array itself sits outside the block.

The block also sequences the device mode at power-up and drives the pin and scan-port enables. A state machine has four states, in this order:

- `MD_QUIET`: the supply is not yet safe.
- `MD_INIT`: user registers are being initialised, for a programmable number of cycles.
- `MD_BLANK`: the device is erased.
- `MD_USER`: user operation.

The transitions are:

- QUIET→INIT when the supply is good.
- INIT→BLANK or INIT→USER when the count expires.
- BLANK→USER after a granted program.
- USER→BLANK after a granted erase.
- Any state→QUIET when the supply is lost.

Top module: `secmode_ctrl`

## Requirements
- R1: After reset the mode is `MD_QUIET` (code 0), no lock is set, pull-ups are on, outputs, inputs and the scan port are disabled, and no grant or deny is raised.
- R2: While `supply_ok` is low, the mode is `MD_QUIET` from the next cycle on, whatever state the machine was in. A request in a cycle with `supply_ok` low is denied.
- R3: The first rising clock edge that sees `supply_ok` in `MD_QUIET` enters `MD_INIT` and loads `init_cycles` = N. The mode stays `MD_INIT` for N+1 cycles. It then moves to `MD_BLANK` (code 2) if the blank flag is set, or to `MD_USER` (code 3) if it is clear.
- R4: Pin enables follow the mode:
  - `MD_QUIET` and `MD_INIT` (code 1): pull-ups on; outputs, inputs and the scan port off.
  - `MD_BLANK`: pull-ups on, outputs and inputs off, scan port on.
  - `MD_USER`: pull-ups off; outputs, inputs and the scan port on.
- R5: A read request (`req_op`=0) is granted only when the read lock is clear.
- R6: A program request (`req_op`=1) is granted only when both locks are clear. A granted program clears the blank flag, and `MD_BLANK` moves to `MD_USER` one cycle later.
- R7: An erase request (`req_op`=2) is granted whenever the write lock is clear, even with the read lock set. A granted erase clears the read lock and sets the blank flag, and `MD_USER` moves to `MD_BLANK` one cycle later. The read lock falls only through a granted erase.
- R8: A lock request (`req_op`=3) is always granted in an active mode. It ORs `req_set_rlock` into the read lock, so it can never clear that lock, and it loads `req_wlock` into the write lock.
- R9: A request is denied when it is made outside `MD_BLANK`/`MD_USER` or when a lock forbids it. A denied request gives a single-cycle `deny_pulse`, no grant, and leaves both locks and the blank flag unchanged.
- R10: Grant and deny appear in the cycle after the request. At most one of the four grant flags and the deny pulse is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (factory-erased state) |
| supply_ok | input | 1 | Supply reported safe |
| init_cycles | input | CNT_W | Register initialisation length N |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 set locks |
| req_set_rlock | input | 1 | Lock request: set read lock |
| req_wlock | input | 1 | Lock request: new write-lock value |
| grant_read | output | 1 | Read granted |
| grant_prog | output | 1 | Program granted |
| grant_erase | output | 1 | Erase granted |
| grant_lock | output | 1 | Lock request granted |
| deny_pulse | output | 1 | Request refused |
| rd_lock | output | 1 | Read lock state |
| wr_lock | output | 1 | Write lock state |
| mode_state | output | 2 | Current mode code |
| pullup_en | output | 1 | I/O pull-ups enabled |
| out_en | output | 1 | Outputs enabled |
| in_en | output | 1 | Inputs and clocks enabled |
| scan_en | output | 1 | Configuration scan port enabled |

## Verification
Two events can fall in the same cycle: a lock decision on a request and a mode change. The first case is a request made in the cycle where `supply_ok` drops, which must be denied. The second is a granted program or erase, whose blank-flag change moves the mode one cycle later, while any request in between is still judged by the old mode. Directed sequences provoke both cases. Random traffic with occasional supply drops covers the rest. A cycle-level reference model in the bench, built from the requirements, judges every output after every edge.

// File: rtl/secmode_pkg.sv
package secmode_pkg;
    typedef enum logic [1:0] {
        MD_QUIET = 2'd0,
        MD_INIT  = 2'd1,
        MD_BLANK = 2'd2,
        MD_USER  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_ERASE = 2'd2,
        OP_LOCK = 2'd3
    } op_e;

    localparam int NUM_OPS = 4;
endpackage

// File: rtl/secmode_fsm.sv
module secmode_fsm
    import secmode_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic [CNT_W-1:0] init_cycles,
    input  logic             blank,
    output mode_e            mode
);
    mode_e            state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MD_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!supply_ok) begin
            state_d = MD_QUIET;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                MD_QUIET: begin
                    state_d = MD_INIT;
                    cnt_d   = init_cycles;
                end
                MD_INIT: begin
                    if (cnt_q == '0) state_d = blank ? MD_BLANK : MD_USER;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                MD_BLANK: if (!blank) state_d = MD_USER;
                MD_USER:  if (blank)  state_d = MD_BLANK;
            endcase
        end
    end

    assign mode = state_q;

    AST_SUPPLY_LOSS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == MD_QUIET)); // R2

    AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_INIT && cnt_q == '0 && supply_ok) |=>
        (state_q == MD_BLANK || state_q == MD_USER)); // R3

    AST_QUIET_TO_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_QUIET && supply_ok) |=> (state_q == MD_INIT)); // R3
endmodule

// File: rtl/secmode_gate.sv
module secmode_gate
    import secmode_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                access_ok,
    input  logic                req_valid,
    input  op_e                 req_op,
    input  logic                req_set_rlock,
    input  logic                req_wlock,
    output logic [NUM_OPS-1:0]  grant,
    output logic                deny,
    output logic                rlock,
    output logic                wlock,
    output logic                blank
);
    logic [NUM_OPS-1:0] grant_q;
    logic               deny_q, rlock_q, wlock_q, blank_q;
    logic               allowed, take;

    always_comb begin
        unique case (req_op)
            OP_READ:  allowed = !rlock_q;
            OP_PROG:  allowed = !rlock_q && !wlock_q;
            OP_ERASE: allowed = !wlock_q;
            OP_LOCK:  allowed = 1'b1;
        endcase
    end

    assign take = req_valid && access_ok && allowed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            deny_q  <= 1'b0;
            rlock_q <= 1'b0;
            wlock_q <= 1'b0;
            blank_q <= 1'b1;
        end else begin
            grant_q <= take ? (NUM_OPS'(1) << req_op) : '0;
            deny_q  <= req_valid && !take;
            if (take) begin
                unique case (req_op)
                    OP_READ: ;
                    OP_PROG: blank_q <= 1'b0;
                    OP_ERASE: begin
                        blank_q <= 1'b1;
                        rlock_q <= 1'b0;
                    end
                    OP_LOCK: begin
                        rlock_q <= rlock_q | req_set_rlock;
                        wlock_q <= req_wlock;
                    end
                endcase
            end
        end
    end

    assign grant = grant_q;
    assign deny  = deny_q;
    assign rlock = rlock_q;
    assign wlock = wlock_q;
    assign blank = blank_q;

    AST_READ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_READ && rlock_q) |=> (deny_q && !grant_q[OP_READ])); // R5

    AST_PROG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_PROG && (rlock_q || wlock_q)) |=> deny_q); // R6

    AST_ERASE_UNDER_RLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (access_ok && req_valid && req_op == OP_ERASE && !wlock_q) |=> grant_q[OP_ERASE]); // R7

    AST_RLOCK_FALL_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rlock_q) |-> grant_q[OP_ERASE]); // R7

    AST_DENY_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        deny_q |-> ($stable(rlock_q) && $stable(wlock_q) && $stable(blank_q))); // R9

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_q, deny_q})); // R10
endmodule

// File: rtl/secmode_pins.sv
module secmode_pins
    import secmode_pkg::*;
(
    input  mode_e mode,
    output logic  pullup_en,
    output logic  out_en,
    output logic  in_en,
    output logic  scan_en
);
    always_comb begin
        unique case (mode)
            MD_QUIET, MD_INIT: begin
                pullup_en = 1'b1; out_en = 1'b0; in_en = 1'b0; scan_en = 1'b0;
            end
            MD_BLANK: begin
                pullup_en = 1'b1; out_en = 1'b0; in_en = 1'b0; scan_en = 1'b1;
            end
            MD_USER: begin
                pullup_en = 1'b0; out_en = 1'b1; in_en = 1'b1; scan_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/secmode_ctrl.sv
module secmode_ctrl
    import secmode_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic [CNT_W-1:0] init_cycles,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_set_rlock,
    input  logic             req_wlock,
    output logic             grant_read,
    output logic             grant_prog,
    output logic             grant_erase,
    output logic             grant_lock,
    output logic             deny_pulse,
    output logic             rd_lock,
    output logic             wr_lock,
    output logic [1:0]       mode_state,
    output logic             pullup_en,
    output logic             out_en,
    output logic             in_en,
    output logic             scan_en
);
    mode_e              mode;
    logic               blank;
    logic [NUM_OPS-1:0] grant;

    secmode_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .init_cycles (init_cycles),
        .blank       (blank),
        .mode        (mode)
    );

    secmode_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .access_ok     (scan_en && supply_ok),
        .req_valid     (req_valid),
        .req_op        (op_e'(req_op)),
        .req_set_rlock (req_set_rlock),
        .req_wlock     (req_wlock),
        .grant         (grant),
        .deny          (deny_pulse),
        .rlock         (rd_lock),
        .wlock         (wr_lock),
        .blank         (blank)
    );

    secmode_pins u_pins (
        .mode      (mode),
        .pullup_en (pullup_en),
        .out_en    (out_en),
        .in_en     (in_en),
        .scan_en   (scan_en)
    );

    assign grant_read  = grant[OP_READ];
    assign grant_prog  = grant[OP_PROG];
    assign grant_erase = grant[OP_ERASE];
    assign grant_lock  = grant[OP_LOCK];
    assign mode_state  = mode;

    AST_NO_GRANT_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !scan_en) |=> (grant == '0 && deny_pulse)); // R9

    AST_PROG_MOVES_TO_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_prog && mode == MD_BLANK && supply_ok) |=> (mode == MD_USER)); // R6
endmodule

// File: tb/test_secmode_ctrl.sv
module test_secmode_ctrl;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, supply_ok, req_valid, req_set_rlock, req_wlock;
    logic [15:0] init_cycles;
    logic [1:0] req_op, mode_state;
    logic grant_read, grant_prog, grant_erase, grant_lock, deny_pulse;
    logic rd_lock, wr_lock, pullup_en, out_en, in_en, scan_en;

    secmode_ctrl i_secmode_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .init_cycles(init_cycles),
        .req_valid(req_valid), .req_op(req_op), .req_set_rlock(req_set_rlock),
        .req_wlock(req_wlock), .grant_read(grant_read), .grant_prog(grant_prog),
        .grant_erase(grant_erase), .grant_lock(grant_lock), .deny_pulse(deny_pulse),
        .rd_lock(rd_lock), .wr_lock(wr_lock), .mode_state(mode_state),
        .pullup_en(pullup_en), .out_en(out_en), .in_en(in_en), .scan_en(scan_en)
    );

    int total = 0, bad = 0;
    bit done = 0;
    int m_mode, m_cnt;
    bit m_blank, m_rl, m_wl, m_den;
    bit [3:0] m_gnt;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit op_allowed(int op);
        case (op)
            0: return !m_rl;
            1: return !m_rl && !m_wl;
            2: return !m_wl;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int next_mode();
        if (!supply_ok) return 0;
        case (m_mode)
            0: return 1;
            1: return (m_cnt == 0) ? (m_blank ? 2 : 3) : 1;
            2: return m_blank ? 2 : 3;
            default: return m_blank ? 2 : 3;
        endcase
    endfunction

    task automatic model_edge();
        bit act, tk;
        int nm;
        act = supply_ok && (m_mode >= 2);
        tk  = req_valid && act && op_allowed(int'(req_op));
        nm  = next_mode();
        if (!supply_ok) m_cnt = 0;
        else if (m_mode == 0) m_cnt = int'(init_cycles);
        else if (m_mode == 1 && m_cnt != 0) m_cnt--;
        m_mode = nm;
        m_gnt = tk ? (4'b1 << req_op) : 4'b0;
        m_den = req_valid && !tk;
        if (tk) begin
            case (req_op)
                2'd1: m_blank = 0;
                2'd2: begin m_blank = 1; m_rl = 0; end
                2'd3: begin m_rl = m_rl | req_set_rlock; m_wl = req_wlock; end
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        chk("R3 mode", mode_state, m_mode);
        chk("R4 pins", {pullup_en, out_en, in_en, scan_en},
            {m_mode < 3, m_mode == 3, m_mode == 3, m_mode >= 2});
        chk("R10 grant", {grant_lock, grant_erase, grant_prog, grant_read}, m_gnt);
        chk("R9 deny", deny_pulse, m_den);
        chk("R8 locks", {rd_lock, wr_lock}, {m_rl, m_wl});
    endtask

    task automatic cyc(bit sv, bit v, int op, bit sr, bit w);
        supply_ok = sv; req_valid = v; req_op = 2'(op);
        req_set_rlock = sr; req_wlock = w;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1500000;
        total++; bad++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; supply_ok = 0; req_valid = 0; req_op = 0;
        req_set_rlock = 0; req_wlock = 0; init_cycles = 16'd3;
        m_mode = 0; m_cnt = 0; m_blank = 1; m_rl = 0; m_wl = 0; m_den = 0; m_gnt = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode_state, 0);
        chk("R1 pins", {pullup_en, out_en, in_en, scan_en}, 4'b1000);
        chk("R1 locks", {rd_lock, wr_lock}, 0);
        chk("R1 resp", {grant_read, grant_prog, grant_erase, grant_lock, deny_pulse}, 0);
        rst_n = 1;
        // R2 held quiet and request denied while supply low
        cyc(0, 1, 0, 0, 0);
        chk("R2 quiet", mode_state, 0);
        chk("R2 deny", deny_pulse, 1);
        // R3 init lasts N+1 cycles
        cyc(1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
        chk("R3 still init", mode_state, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R3 to blank", mode_state, 2);
        chk("R4 blank scan", scan_en, 1);
        // R5 read open
        cyc(1, 1, 0, 0, 0);
        chk("R5 read ok", grant_read, 1);
        // R6 program moves to user
        cyc(1, 1, 1, 0, 0);
        chk("R6 prog ok", grant_prog, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R6 user", mode_state, 3);
        // R8 set read lock
        cyc(1, 1, 3, 1, 0);
        chk("R8 rlock set", rd_lock, 1);
        cyc(1, 1, 3, 0, 0);
        chk("R8 rlock not cleared", rd_lock, 1);
        cyc(1, 1, 0, 0, 0);
        chk("R5 read denied", deny_pulse, 1);
        cyc(1, 1, 1, 0, 0);
        chk("R6 prog denied", deny_pulse, 1);
        // R7 erase under read lock
        cyc(1, 1, 2, 0, 0);
        chk("R7 erase ok", grant_erase, 1);
        chk("R7 rlock cleared", rd_lock, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R7 blank mode", mode_state, 2);
        // R7/R9 write lock blocks erase
        cyc(1, 1, 3, 0, 1);
        cyc(1, 1, 2, 0, 0);
        chk("R7 erase denied", deny_pulse, 1);
        chk("R9 wlock kept", wr_lock, 1);
        cyc(1, 1, 3, 0, 0);
        chk("R8 wlock cleared", wr_lock, 0);
        // R2 request in the cycle supply drops
        cyc(1, 1, 1, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R2 drop deny", deny_pulse, 1);
        chk("R2 drop quiet", mode_state, 0);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (m_mode == 0) init_cycles = 16'($urandom_range(0, 5));
            cyc(($urandom_range(0, 63) != 0), $urandom_range(0, 1), $urandom_range(0, 3),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0));
        end
        finish_run();
    end
endmodule